// File: doc/BRIEF.md
# Row Input Routing Synchronizer

This block feeds four row input signals from two 8-bit global buses, one even and one odd. Each row input has its own 4-to-1 selector. The selector for input k reaches four global lines: even line k, even line k+4, odd line k and odd line k+4. Taken together, the four selectors cover all sixteen global lines.

Each selected line then goes through a two-flop synchronizer clocked by the system clock. A per-input bypass bit can turn the synchronizer off. In that case the selected line goes straight to the row input through combinational logic.

Two 8-bit configuration registers hold the settings. Software writes them through an address/data/write-enable port and reads them back on the same port. Both registers reset to zero. After reset, every input therefore selects even line k and is synchronized.

Top module: `row_input_router`

## Requirements
- R1: Address 0 holds the select register, where bits [2k+1:2k] choose the source for row input k: code 0 picks even line k, code 1 picks even line k+4, code 2 picks odd line k, code 3 picks odd line k+4.
- R2: Over the four inputs and four codes, each of the 16 global lines can be routed to some row input.
- R3: With bypass bit k at 0, a change on the selected line shows on ri_o[k] after exactly two rising clock edges, and not after one.
- R4: Address 1 holds the bypass register, where bit k set to 1 routes the selected line to ri_o[k] in the same cycle, with no register stage.
- R5: During reset both registers read 0 and ri_o is 0; after reset each input selects even line k and is synchronized.
- R6: rdata_o combinationally shows the register picked by addr_i; bits 7:4 of the bypass register always read 0.
- R7: A write changes only the register picked by addr_i, and nothing changes while wr_en_i is low.
- R8: The bypass bits act per input: bypassed inputs follow their lines at once, while the other inputs keep the two-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gie_i | input | 8 | Even global input bus |
| gio_i | input | 8 | Odd global input bus |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 1 | Register select: 0 select, 1 bypass |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| ri_o | output | 4 | Row input signals |

## Verification
The routing is checked in bypass mode. The bench drives a one-hot value and then an all-but-one value on each of the 16 global lines, and it does this under uniform select codes and under mixed ones. A pin that is routed correctly cannot be mistaken for a neighbour in these patterns, and a swap of even and odd buses or of the low and high halves also shows up. A step on the lines, with output samples after one edge and after two edges, separates correct synchronizer depth from a missing or an extra stage. A partial bypass mask shows whether the bypass acts on each input alone. Writes with the enable low, and writes to the other address, show whether register writes stay where they belong.

// File: rtl/row_in_pkg.sv
package row_in_pkg;
  localparam int NUM_RI  = 4;
  localparam int N_SRC   = 4;
  localparam int SEL_W   = $clog2(N_SRC);
  localparam int BUS_W   = 2 * NUM_RI;
  localparam int DATA_W  = 8;
  localparam int SEL_REG_W = NUM_RI * SEL_W;
endpackage

// File: rtl/row_in_cfg.sv
module row_in_cfg
  import row_in_pkg::*;
#(
  parameter int NRI  = NUM_RI,
  parameter int SW   = SEL_W,
  parameter int DW   = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NRI*SW-1:0] sel_o,
  output logic [NRI-1:0]    bypass_o
);
  localparam int SRW = NRI * SW;

  logic [SRW-1:0] sel_q;
  logic [NRI-1:0] byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      byp_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i) byp_q <= wdata_i[NRI-1:0];
      else        sel_q <= wdata_i[SRW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) rdata_o[NRI-1:0] = byp_q;
    else        rdata_o[SRW-1:0] = sel_q;
  end

  assign sel_o    = sel_q;
  assign bypass_o = byp_q;

  // R7: a write leaves the other register alone
  p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !addr_i) |=> $stable(sel_q));
  p_byp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i) |=> $stable(byp_q));
  // R1: select write lands
  p_sel_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> sel_q == $past(wdata_i[SRW-1:0]));

  // R5: registers cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r5: assert (sel_q == '0 && byp_q == '0);
    end
  end
endmodule

// File: rtl/row_in_mux.sv
module row_in_mux
  import row_in_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int SW = SEL_W
) (
  input  logic [NS-1:0] src_i,
  input  logic [SW-1:0] sel_i,
  output logic          y_o
);
  assign y_o = src_i[sel_i];
endmodule

// File: rtl/row_in_sync.sv
module row_in_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic bypass_i,
  output logic q_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = bypass_i ? d_i : ff2_q;

  // cycles since reset, so $past never reaches into reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= {age_q[0], 1'b1};
  end

  // R3: synchronized output equals input two edges earlier
  p_two_stage_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q[1] && !bypass_i) |-> q_o == $past(d_i, 2));
endmodule

// File: rtl/row_input_router.sv
module row_input_router
  import row_in_pkg::*;
#(
  parameter int NRI = NUM_RI,
  parameter int DW  = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2*NRI-1:0] gie_i,
  input  logic [2*NRI-1:0] gio_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NRI-1:0]   ri_o
);
  localparam int SW = SEL_W;

  logic [NRI*SW-1:0] sel;
  logic [NRI-1:0]    bypass;
  logic [NRI-1:0]    mux_y;

  row_in_cfg #(.NRI(NRI), .SW(SW), .DW(DW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .sel_o    (sel),
    .bypass_o (bypass)
  );

  for (genvar k = 0; k < NRI; k++) begin : g_ri
    logic [N_SRC-1:0] cand;
    // code order: even k, even k+NRI, odd k, odd k+NRI
    assign cand = {gio_i[k+NRI], gio_i[k], gie_i[k+NRI], gie_i[k]};

    row_in_mux #(.NS(N_SRC), .SW(SW)) u_mux (
      .src_i (cand),
      .sel_i (sel[k*SW +: SW]),
      .y_o   (mux_y[k])
    );

    row_in_sync u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (mux_y[k]),
      .bypass_i (bypass[k]),
      .q_o      (ri_o[k])
    );

    // R4 / R1: bypassed inputs track the chosen global line
    p_route_even_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bypass[k] && sel[k*SW +: SW] == 2'd0) |-> ri_o[k] == gie_i[k]);
    p_route_odd_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bypass[k] && sel[k*SW +: SW] == 2'd3) |-> ri_o[k] == gio_i[k+NRI]);
  end
endmodule

// File: tb/row_input_router_bench.sv
module row_input_router_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] gie, gio, wdata;
  logic       wr_en, addr;
  logic [7:0] rdata;
  logic [3:0] ri;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  row_input_router u_row_input_router (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .gio_i(gio),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ri_o(ri)
  );

  function automatic logic [3:0] exp_ri(input logic [7:0] s, input logic [7:0] e, input logic [7:0] o);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      case (s[2*k +: 2])
        2'd0: r[k] = e[k];
        2'd1: r[k] = e[k+4];
        2'd2: r[k] = o[k];
        default: r[k] = o[k+4];
      endcase
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] sel_list [6];
    logic [15:0] reached;
    logic [3:0] e_old, e_new;
    sel_list[0] = 8'h00; sel_list[1] = 8'h55; sel_list[2] = 8'hAA;
    sel_list[3] = 8'hFF; sel_list[4] = 8'hE4; sel_list[5] = 8'h1B;
    reached = '0;
    rst_n = 1'b0; gie = 8'hFF; gio = 8'hFF; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R5: reset state
    rd_chk(1'b0, 8'h00, "R5 sel reset");
    rd_chk(1'b1, 8'h00, "R5 bypass reset");
    chk(ri == 4'h0, "R5 ri reset", {4'h0, ri}, 8'h00);
    gie = 8'h00; gio = 8'h00;
    @(negedge clk); rst_n = 1'b1;
    settle();
    // R5: default selects even k, synchronized
    gie = 8'h0A; gio = 8'hFF;
    @(posedge clk); @(negedge clk);
    chk(ri == 4'h0, "R5 default sync one edge", {4'h0, ri}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk(ri == 4'hA, "R5 default select", {4'h0, ri}, 8'h0A);

    // R6: bypass readback masks upper bits
    wr(1'b1, 8'hFF);
    rd_chk(1'b1, 8'h0F, "R6 bypass readback");

    // R1/R2/R4: bypass routing sweep
    for (int s = 0; s < 6; s++) begin
      wr(1'b0, sel_list[s]);
      rd_chk(1'b0, sel_list[s], "R6 select readback");
      for (int j = 0; j < 16; j++) begin
        for (int inv = 0; inv < 2; inv++) begin
          logic [15:0] v;
          v = 16'h1 << j;
          if (inv == 1) v = ~v;
          gie = v[7:0]; gio = v[15:8];
          #1;
          e_new = exp_ri(sel_list[s], gie, gio);
          chk(ri == e_new, "R1 R4 bypass route", {4'h0, ri}, {4'h0, e_new});
          if (inv == 0 && ri != 4'h0) reached[j] = 1'b1;
        end
      end
    end
    chk(reached == 16'hFFFF, "R2 all lines reachable", reached[7:0] & reached[15:8], 8'hFF);

    // R3: synchronized latency, mixed codes
    wr(1'b1, 8'h00);
    for (int s = 4; s < 6; s++) begin
      wr(1'b0, sel_list[s]);
      for (int p = 0; p < 4; p++) begin
        gie = 8'h00; gio = 8'h00;
        settle();
        e_old = exp_ri(sel_list[s], gie, gio);
        gie = 8'h11 << p; gio = 8'h11 << p;
        e_new = exp_ri(sel_list[s], gie, gio);
        #1;
        chk(ri == e_old, "R3 no change same cycle", {4'h0, ri}, {4'h0, e_old});
        @(posedge clk); @(negedge clk);
        chk(ri == e_old, "R3 no change after one edge", {4'h0, ri}, {4'h0, e_old});
        @(posedge clk); @(negedge clk);
        chk(ri == e_new, "R3 change after two edges", {4'h0, ri}, {4'h0, e_new});
      end
    end

    // R8: partial bypass
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h05);
    gie = 8'h00; gio = 8'h00;
    settle();
    gie = 8'h0F;
    #1;
    chk(ri == 4'h5, "R8 bypassed only at once", {4'h0, ri}, 8'h05);
    @(posedge clk); @(negedge clk);
    chk(ri == 4'h5, "R8 synced lag one edge", {4'h0, ri}, 8'h05);
    @(posedge clk); @(negedge clk);
    chk(ri == 4'hF, "R8 synced after two edges", {4'h0, ri}, 8'h0F);

    // R7: write isolation
    wr(1'b0, 8'h9C);
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = 8'h33;
    @(posedge clk); @(negedge clk);
    rd_chk(1'b0, 8'h9C, "R7 no write when disabled");
    wr(1'b1, 8'h0A);
    rd_chk(1'b0, 8'h9C, "R7 bypass write keeps select");
    rd_chk(1'b1, 8'h0A, "R7 bypass write lands");
    wr(1'b0, 8'h27);
    rd_chk(1'b1, 8'h0A, "R7 select write keeps bypass");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule